// File: doc/BRIEF.md
# PLL Retune Sequencer

This block owns the 32-bit control word of a phase-locked loop and changes the loop's settings without letting an unlocked clock reach downstream logic. A caller asks for a new feedback multiplier code and post-divider exponent through a valid/ready request. Four further operation codes bring the loop out of reset, put it into reset, and set or clear the output enable.

When the multiplier changes, the block routes the output around the loop and resets the loop. It loads the new dividers under reset, releases the reset, and then waits for the short lock flag and the long lock flag, in that order. Only after both flags does it enable the output and end the bypass. When only the post-divider changes, the loop stays locked: the block swaps the divider behind the bypass and then ends the bypass. A timer bounds each lock wait. The block also computes the output rate that the current word selects.

Top module: `pll_retune_seq`

## Requirements
- R1: The control word places external enable at bit 0, external bypass at bit 1, loop reset at bit 2, internal bypass at bit 3, range at bits 6:4, reference divider at bits 12:8, post-divider exponent at bits 18:16, multiplier code at bits 27:20, the short lock flag at bit 28 and the long lock flag at bit 29. Bits 31:30 read zero. After reset, loop reset and external bypass are 1, enable is 0, and the divider fields hold their parameter values.
- R2: A retune whose multiplier code differs from the stored one writes the word once per cycle in this order: bypass set at the accept edge, then reset set with the old dividers, then the new multiplier and exponent with reset still set, then reset cleared.
- R3: After the reset is released, the sequencer waits for the short lock input and then for the long lock input. At the edge where the long lock is seen, it sets enable and clears external bypass together.
- R4: A retune with an unchanged multiplier never touches the reset bit. It sets bypass at the accept edge, writes the exponent on the next edge, and clears bypass on the edge after that.
- R5: `rate_o` equals REF_RATE × (multiplier + 1) / 2^exponent, and equals REF_RATE while external bypass is set.
- R6: A requested exponent of 0 is stored as 1, and one of 7 is stored as 6. Exponents 1 to 6 are stored unchanged.
- R7: Operation code 1 (power up) clears reset and then waits for both lock inputs without changing enable or bypass. Code 2 (power down) sets reset. Code 3 sets enable and code 4 clears it. Codes 2 to 4 complete at their accept edge. Code 0 is retune.
- R8: `req_ready` is high only while the sequencer is idle. A request presented while busy is ignored.
- R9: If a lock wait lasts LOCK_TIMEOUT cycles, the sequencer sets `err_o` and returns to idle with external bypass still set. The error clears at the next accepted request.
- R10: The reference divider, range and internal bypass fields never change.
- R11: `busy_o` is high from the accept edge until the final write. `done_o` pulses for one cycle at the edge of that final write. A timed-out wait gives no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted at this edge |
| req_op | input | 3 | Operation: 0 retune, 1 power up, 2 power down, 3 enable, 4 disable |
| req_mult | input | 8 | Requested multiplier code |
| req_pdiv | input | 3 | Requested post-divider exponent |
| lock_i | input | 1 | Short lock flag from the loop |
| lock_long_i | input | 1 | Long lock flag from the loop |
| ctrl_o | output | 32 | Control word driven to the loop, with the lock flags in their status bits |
| rate_o | output | 32 | Output rate selected by the current word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Lock wait timed out |

## Verification
Each write of the sequence appears on `ctrl_o` one clock edge after the previous one. The first write appears at the accept edge. `rate_o` follows the registered word in the same cycle, and `done_o` and the drop of `busy_o` come at the edge of the final write. A lock flag that rises is acted on at the next edge, and a timeout lands on the edge that ends the LOCK_TIMEOUT-th waiting cycle. The bench steps a queued reference model at every rising edge and compares all outputs on the falling edge after it. A lock model reacts to the reset bit with fixed delays, and can be held off to force the timeout.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int MULT_W   = 8;
    localparam int PDIV_W   = 3;
    localparam int REFDIV_W = 5;
    localparam int RANGE_W  = 3;
    localparam int OP_W     = 3;
    localparam logic [PDIV_W-1:0] PDIV_MIN = 3'd1;
    localparam logic [PDIV_W-1:0] PDIV_MAX = 3'd6;

    // control word; bit positions are decoded by the loop
    typedef struct packed {
        logic [1:0]          rsv_hi;     // 31:30
        logic                lock_long;  // 29
        logic                lock;       // 28
        logic [MULT_W-1:0]   mult;       // 27:20
        logic                rsv19;      // 19
        logic [PDIV_W-1:0]   pdiv;       // 18:16
        logic [2:0]          rsv15;      // 15:13
        logic [REFDIV_W-1:0] refdiv;     // 12:8
        logic                rsv7;       // 7
        logic [RANGE_W-1:0]  range;      // 6:4
        logic                int_byp;    // 3
        logic                rst;        // 2
        logic                xbyp;       // 1
        logic                xen;        // 0
    } ctrl_t;

    typedef enum logic [OP_W-1:0] {
        OP_RETUNE  = 3'd0,
        OP_PWRUP   = 3'd1,
        OP_PWRDN   = 3'd2,
        OP_ENABLE  = 3'd3,
        OP_DISABLE = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ASSERT_RST,
        ST_LOAD_DIV,
        ST_RELEASE,
        ST_WAIT_LOCK,
        ST_WAIT_LONG,
        ST_LOAD_PDIV,
        ST_UNBYPASS
    } seq_st_e;

    function automatic logic [PDIV_W-1:0] clamp_pdiv(input logic [PDIV_W-1:0] p);
        if (p < PDIV_MIN) return PDIV_MIN;
        if (p > PDIV_MAX) return PDIV_MAX;
        return p;
    endfunction

endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (run_i && !expired_o)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R9

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
    parameter int REF_RATE = 25,
    parameter int RATE_W   = 32
) (
    input  logic [pll_seq_pkg::MULT_W-1:0] mult_i,
    input  logic [pll_seq_pkg::PDIV_W-1:0] pdiv_i,
    input  logic                           xbyp_i,
    output logic [RATE_W-1:0]              rate_o
);
    localparam logic [RATE_W-1:0] REF_V = RATE_W'(REF_RATE);

    logic [RATE_W-1:0] vco;

    always_comb begin
        vco    = REF_V * (RATE_W'(mult_i) + 1'b1);
        rate_o = xbyp_i ? REF_V : (vco >> pdiv_i);
    end

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_seq_pkg::*;
#(
    parameter int          REF_RATE     = 25,
    parameter int          RATE_W       = 32,
    parameter int          LOCK_TIMEOUT = 64,
    parameter logic [7:0]  RST_MULT     = 8'd63,
    parameter logic [2:0]  RST_PDIV     = 3'd1,
    parameter logic [4:0]  RST_REFDIV   = 5'd3,
    parameter logic [2:0]  RST_RANGE    = 3'd2,
    parameter logic        RST_INT_BYP  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [7:0]        req_mult,
    input  logic [2:0]        req_pdiv,
    input  logic              lock_i,
    input  logic              lock_long_i,
    output logic [31:0]       ctrl_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        seq_st_e           state;
        ctrl_t             ctrl;
        logic [MULT_W-1:0] tgt_mult;
        logic [PDIV_W-1:0] tgt_pdiv;
        logic              relock_fin;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;
    logic tmr_clr, tmr_run, tmr_exp;
    ctrl_t ctrl_view;

    function automatic ctrl_t reset_word();
        ctrl_t c;
        c         = '0;
        c.mult    = RST_MULT;
        c.pdiv    = RST_PDIV;
        c.refdiv  = RST_REFDIV;
        c.range   = RST_RANGE;
        c.int_byp = RST_INT_BYP;
        c.rst     = 1'b1;
        c.xbyp    = 1'b1;
        return c;
    endfunction

    assign tmr_run = (seq_q.state == ST_WAIT_LOCK) || (seq_q.state == ST_WAIT_LONG);
    assign tmr_clr = (seq_d.state != seq_q.state);

    pll_lock_timer #(.LIMIT(LOCK_TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .run_i     (tmr_run),
        .expired_o (tmr_exp)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.err = 1'b0;
                    case (req_op)
                        OP_RETUNE: begin
                            seq_d.tgt_mult   = req_mult;
                            seq_d.tgt_pdiv   = clamp_pdiv(req_pdiv);
                            seq_d.relock_fin = 1'b1;
                            seq_d.ctrl.xbyp  = 1'b1;
                            seq_d.state      = (req_mult != seq_q.ctrl.mult)
                                               ? ST_ASSERT_RST : ST_LOAD_PDIV;
                        end
                        OP_PWRUP: begin
                            seq_d.ctrl.rst   = 1'b0;
                            seq_d.relock_fin = 1'b0;
                            seq_d.state      = ST_WAIT_LOCK;
                        end
                        OP_PWRDN: begin
                            seq_d.ctrl.rst = 1'b1;
                            seq_d.done     = 1'b1;
                        end
                        OP_ENABLE: begin
                            seq_d.ctrl.xen = 1'b1;
                            seq_d.done     = 1'b1;
                        end
                        OP_DISABLE: begin
                            seq_d.ctrl.xen = 1'b0;
                            seq_d.done     = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_ASSERT_RST: begin
                seq_d.ctrl.rst = 1'b1;
                seq_d.state    = ST_LOAD_DIV;
            end
            ST_LOAD_DIV: begin
                seq_d.ctrl.mult = seq_q.tgt_mult;
                seq_d.ctrl.pdiv = seq_q.tgt_pdiv;
                seq_d.state     = ST_RELEASE;
            end
            ST_RELEASE: begin
                seq_d.ctrl.rst = 1'b0;
                seq_d.state    = ST_WAIT_LOCK;
            end
            ST_WAIT_LOCK: begin
                if (lock_i) begin
                    seq_d.state = ST_WAIT_LONG;
                end else if (tmr_exp) begin
                    seq_d.err   = 1'b1;
                    seq_d.state = ST_IDLE;
                end
            end
            ST_WAIT_LONG: begin
                if (lock_long_i) begin
                    if (seq_q.relock_fin) begin
                        seq_d.ctrl.xen  = 1'b1;
                        seq_d.ctrl.xbyp = 1'b0;
                    end
                    seq_d.done  = 1'b1;
                    seq_d.state = ST_IDLE;
                end else if (tmr_exp) begin
                    seq_d.err   = 1'b1;
                    seq_d.state = ST_IDLE;
                end
            end
            ST_LOAD_PDIV: begin
                seq_d.ctrl.pdiv = seq_q.tgt_pdiv;
                seq_d.state     = ST_UNBYPASS;
            end
            ST_UNBYPASS: begin
                seq_d.ctrl.xbyp = 1'b0;
                seq_d.done      = 1'b1;
                seq_d.state     = ST_IDLE;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q            <= '0;
            seq_q.state      <= ST_IDLE;
            seq_q.ctrl       <= reset_word();
            seq_q.tgt_mult   <= RST_MULT;
            seq_q.tgt_pdiv   <= RST_PDIV;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        ctrl_view           = seq_q.ctrl;
        ctrl_view.lock      = lock_i;
        ctrl_view.lock_long = lock_long_i;
    end

    assign ctrl_o    = ctrl_view;
    assign req_ready = (seq_q.state == ST_IDLE);
    assign busy_o    = (seq_q.state != ST_IDLE);
    assign done_o    = seq_q.done;
    assign err_o     = seq_q.err;

    pll_rate_calc #(.REF_RATE(REF_RATE), .RATE_W(RATE_W)) u_rate (
        .mult_i (seq_q.ctrl.mult),
        .pdiv_i (seq_q.ctrl.pdiv),
        .xbyp_i (seq_q.ctrl.xbyp),
        .rate_o (rate_o)
    );

    AST_MULT_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ctrl.mult != $past(seq_q.ctrl.mult)) |-> seq_q.ctrl.rst); // R2

    AST_UNBYPASS_AFTER_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(seq_q.ctrl.xbyp) && $rose(seq_q.ctrl.xen)) |-> $past(lock_long_i)); // R3

    AST_PDIV_BEHIND_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ctrl.pdiv != $past(seq_q.ctrl.pdiv)) |-> seq_q.ctrl.xbyp); // R4

    AST_PDIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ctrl.pdiv >= PDIV_MIN) && (seq_q.ctrl.pdiv <= PDIV_MAX)); // R6

    AST_ERR_KEEPS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> seq_q.ctrl.xbyp); // R9

    AST_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({seq_q.ctrl.refdiv, seq_q.ctrl.range, seq_q.ctrl.int_byp})); // R10

endmodule

// File: tb/sim_pll_retune_seq.sv
module sim_pll_retune_seq;

    localparam int REF      = 25;
    localparam int TMO      = 64;
    localparam int LOCK_DLY = 10;
    localparam int LONG_DLY = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = '0;
    logic [7:0] req_mult = '0;
    logic [2:0] req_pdiv = '0;
    logic lock_i = 1'b0;
    logic lock_long_i = 1'b0;
    logic [31:0] ctrl_o;
    logic [31:0] rate_o;
    logic busy_o, done_o, err_o;

    always #10 clk = ~clk;

    pll_retune_seq #(.REF_RATE(REF), .LOCK_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_mult(req_mult), .req_pdiv(req_pdiv),
        .lock_i(lock_i), .lock_long_i(lock_long_i), .ctrl_o(ctrl_o),
        .rate_o(rate_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    int checks = 0;
    int fails  = 0;
    string scen = "R1";
    bit lock_en = 1'b1;
    bit finished = 1'b0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // lock model: counts cycles since the loop reset was released
    int lk_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n || ctrl_o[2] || !lock_en) begin
            lk_cnt = 0; lock_i = 1'b0; lock_long_i = 1'b0;
        end else begin
            lk_cnt++;
            lock_i      = (lk_cnt >= LOCK_DLY);
            lock_long_i = (lk_cnt >= LONG_DLY);
        end
    end

    // reference model: queued word steps, then lock waits
    localparam logic [31:0] RST_WORD = (32'd63 << 20) | (32'd1 << 16) | (32'd3 << 8)
                                     | (32'd2 << 4) | 32'h6;
    logic [31:0] m_ctrl = RST_WORD;
    logic [31:0] stepq[$];
    bit m_busy = 0, m_done = 0, m_err = 0, m_fin = 0;
    int m_wait = 0, m_tcnt = 0;

    function automatic int clampi(int p);
        return (p < 1) ? 1 : ((p > 6) ? 6 : p);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = RST_WORD; stepq.delete(); m_busy = 0; m_done = 0; m_err = 0;
            m_wait = 0; m_tcnt = 0; m_fin = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (req_valid) begin
                    m_err = 0;
                    case (req_op)
                        3'd0: begin
                            logic [31:0] w;
                            int pd;
                            pd = clampi(int'(req_pdiv));
                            m_ctrl[1] = 1'b1;
                            m_busy = 1; m_fin = 1;
                            if (req_mult != m_ctrl[27:20]) begin
                                w = m_ctrl | 32'h4;
                                stepq.push_back(w);
                                w[27:20] = req_mult; w[18:16] = 3'(pd);
                                stepq.push_back(w);
                                w[2] = 1'b0;
                                stepq.push_back(w | 32'h4000_0000);
                            end else begin
                                w = m_ctrl; w[18:16] = 3'(pd);
                                stepq.push_back(w);
                                w[1] = 1'b0;
                                stepq.push_back(w | 32'h8000_0000);
                            end
                        end
                        3'd1: begin m_ctrl[2] = 0; m_busy = 1; m_fin = 0; m_wait = 1; m_tcnt = 0; end
                        3'd2: begin m_ctrl[2] = 1; m_done = 1; end
                        3'd3: begin m_ctrl[0] = 1; m_done = 1; end
                        3'd4: begin m_ctrl[0] = 0; m_done = 1; end
                        default: ;
                    endcase
                end
            end else if (stepq.size() > 0) begin
                logic [31:0] v;
                v = stepq.pop_front();
                m_ctrl = {4'b0, v[27:0]};
                if (v[31]) begin m_done = 1; m_busy = 0; end
                if (v[30]) begin m_wait = 1; m_tcnt = 0; end
            end else if (m_wait == 1) begin
                if (lock_i) begin m_wait = 2; m_tcnt = 0; end
                else if (m_tcnt == TMO - 1) begin m_err = 1; m_busy = 0; m_wait = 0; end
                else m_tcnt++;
            end else if (m_wait == 2) begin
                if (lock_long_i) begin
                    if (m_fin) begin m_ctrl[0] = 1; m_ctrl[1] = 0; end
                    m_done = 1; m_busy = 0; m_wait = 0;
                end else if (m_tcnt == TMO - 1) begin m_err = 1; m_busy = 0; m_wait = 0; end
                else m_tcnt++;
            end
        end
    end

    function automatic logic [31:0] exp_rate(logic [31:0] w);
        if (w[1]) return 32'(REF);
        return 32'((REF * (int'(w[27:20]) + 1)) / (1 << int'(w[18:16])));
    endfunction

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            chk({scen, " R1 word"}, ctrl_o, m_ctrl | {2'b0, lock_long_i, lock_i, 28'b0});
            chk("R5 rate", rate_o, exp_rate(m_ctrl));
            chk("R8 ready", 32'(req_ready), 32'(!m_busy));
            chk("R11 busy", 32'(busy_o), 32'(m_busy));
            chk("R11 done", 32'(done_o), 32'(m_done));
            chk("R9 err", 32'(err_o), 32'(m_err));
        end
    end

    task automatic issue(logic [2:0] op, logic [7:0] m, logic [2:0] p);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_mult = m; req_pdiv = p;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset word
        chk("R1 reset word", ctrl_o, RST_WORD);
        chk("R5 rate in bypass", rate_o, 32'(REF));
        rst_n = 1'b1;

        scen = "R7";
        issue(3'd1, 8'd0, 3'd0);
        wait_idle();
        chk("R7 power up releases reset", 32'(ctrl_o[2]), 32'd0);
        chk("R7 power up leaves enable", 32'(ctrl_o[0]), 32'd0);
        issue(3'd3, 8'd0, 3'd0);
        chk("R7 enable set", 32'(ctrl_o[0]), 32'd1);

        scen = "R2";
        issue(3'd0, 8'd84, 3'd2);
        // R8: a request pulsed while busy must be ignored
        req_valid = 1'b1; req_op = 3'd0; req_mult = 8'd5; req_pdiv = 3'd3;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk("R8 busy request ignored", 32'(ctrl_o[27:20]), 32'd84);
        chk("R3 bypass cleared after lock", 32'(ctrl_o[1:0]), 32'b01);
        chk("R5 rate after relock", rate_o, 32'(25 * 85 / 4));

        scen = "R4";
        issue(3'd0, 8'd84, 3'd5);
        wait_idle();
        chk("R4 exponent updated", 32'(ctrl_o[18:16]), 32'd5);
        chk("R4 reset untouched", 32'(ctrl_o[2]), 32'd0);

        scen = "R6";
        issue(3'd0, 8'd84, 3'd0);
        wait_idle();
        chk("R6 exponent 0 to 1", 32'(ctrl_o[18:16]), 32'd1);
        issue(3'd0, 8'd100, 3'd7);
        wait_idle();
        chk("R6 exponent 7 to 6", 32'(ctrl_o[18:16]), 32'd6);

        scen = "R9";
        lock_en = 1'b0;
        issue(3'd0, 8'd40, 3'd3);
        wait_idle();
        chk("R9 error raised", 32'(err_o), 32'd1);
        chk("R9 bypass kept", 32'(ctrl_o[1]), 32'd1);
        lock_en = 1'b1;
        issue(3'd0, 8'd41, 3'd3);
        wait_idle();
        chk("R9 error cleared on next request", 32'(err_o), 32'd0);

        scen = "R7";
        issue(3'd2, 8'd0, 3'd0);
        chk("R7 power down sets reset", 32'(ctrl_o[2]), 32'd1);
        issue(3'd4, 8'd0, 3'd0);
        chk("R7 disable clears enable", 32'(ctrl_o[0]), 32'd0);
        chk("R10 fixed fields", {19'b0, ctrl_o[12:8], 1'b0, ctrl_o[6:3]},
            {19'b0, 5'd3, 1'b0, 3'd2, 1'b0});
        repeat (3) @(negedge clk);
        summary();
    end

endmodule